// File: doc/BRIEF.md
# String-Aware Data Address Generator

This block produces the data-memory effective address for an instruction. It decodes the low byte of an opcode, reads eight 16-bit pointer registers and an optional second instruction word, and forms an address from one of five modes: direct, indirect, indexed, short page-relative and long register-relative. Register R5 is the index register and R6 is the page register. The register file lives outside the block. The block only reads it and requests a write-back through an index and value pair.

A string instruction is marked by a non-zero length `str_len` = n. It spans n+1 words, least significant word first. The block emits n+1 address beats, and each beat is one above the previous one. In every mode except indirect with a post-modify action, the stepping works on a private copy, so the registers are left unchanged. In indirect mode with a post-modify action, each beat writes the next address back to the selected register. After the last beat, that register points one past the most significant word.

Instructions enter on a valid/ready handshake. `in_ready` is low while a sequence is in flight, and an instruction is taken only on a cycle where both `in_valid` and `in_ready` are high. Addresses leave on a valid/ready handshake. While `out_ready` is low, the current address and its write-back request are held and the sequence does not advance. A write-back is requested only on a beat that is actually taken.

Top module: `str_addr_gen`

## Requirements
- R1: After reset, `in_ready` is high and `addr_valid`, `busy`, `wb_valid` and `err` are low.
- R2: `op[7:5]` selects the mode: 000 direct, 001 indirect, 010 indexed, 011 long relative, 100 short page-relative. `op[4:2]` selects register Rsel and `op[1:0]` selects the post-modify action. In direct mode the address equals the offset word.
- R3: In indirect mode the address is Rsel. With action 00, no write-back is requested.
- R4: In indexed mode the address is Rsel + R5, modulo 2^16.
- R5: In short page-relative mode the address is R6 plus `offset[6:0]` zero-extended. `offset[15:7]` and `op[4:2]` are ignored.
- R6: In long relative mode the address is Rsel + offset, modulo 2^16.
- R7: For a single word (n = 0) in indirect mode, action 01 writes back Rsel+1, action 10 writes back Rsel-1 and action 11 writes back Rsel+R5. The write-back goes to index sel and is requested once, on the taken beat.
- R8: With n > 0, exactly n+1 beats appear, with addresses base, base+1, … base+n, modulo 2^16. `busy` stays high from the first beat through the last and drops after the last beat is taken.
- R9: During a string in any mode other than indirect with an action, no write-back is requested.
- R10: During a string in indirect mode with any non-zero action, every taken beat writes address+1 to Rsel, so the final value written is base+n+1.
- R11: While `addr_valid` is high and `out_ready` is low, `addr` holds, `wb_valid` is low and the sequence does not advance.
- R12: Mode codes 101, 110 and 111, or a non-zero action outside indirect mode, raise `err` for one cycle after acceptance. No address beat and no write-back follow.
- R13: While `busy` is high, `in_ready` is low and `in_valid` has no effect. An accepted instruction yields either a beat or `err` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken (not busy) |
| op | input | 8 | Opcode low byte: mode, register select, post-modify |
| offset | input | 16 | Second instruction word (direct, long and short offsets) |
| str_len | input | 8 | String length n; 0 means a single word |
| regs | input | 128 | R0..R7, with R0 in bits 15:0 |
| out_ready | input | 1 | Consumer takes the current address beat |
| addr_valid | output | 1 | Address beat present |
| addr | output | 16 | Effective address |
| wb_valid | output | 1 | Register write-back request (taken beat only) |
| wb_idx | output | 3 | Register to write back |
| wb_data | output | 16 | Write-back value |
| busy | output | 1 | Sequence in flight |
| err | output | 1 | One-cycle pulse for an undefined encoding |

## Verification
The properties assume that the register values and `str_len` stay stable while a sequence is in flight. They also assume that the consumer may stall `out_ready` at any time. The stimulus changes the register file only between instructions and drives `str_len` only while offering an instruction. It also deliberately raises `in_valid` in the middle of a string and lowers `out_ready` in the middle of a string, so that the hold and the ignore rules are both exercised.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int NREG = 8;
  localparam int SELW = 3;
  localparam int IDX_REG = 5;
  localparam int PAGE_REG = 6;
  localparam int SHORT_W = 7;

  typedef enum logic [2:0] {
    M_DIRECT   = 3'b000,
    M_INDIRECT = 3'b001,
    M_INDEXED  = 3'b010,
    M_LONG     = 3'b011,
    M_SHORT    = 3'b100
  } mode_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_INC  = 2'b01,
    PM_DEC  = 2'b10,
    PM_IDX  = 2'b11
  } pm_e;
endpackage

// File: rtl/sag_base_calc.sv
module sag_base_calc
  import sag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [7:0]         op,
  input  logic [AW-1:0]      offset,
  input  logic [NREG*AW-1:0] regs,
  input  logic               is_str,
  output logic [AW-1:0]      base,
  output logic [AW-1:0]      step,
  output logic               wb_en,
  output logic [SELW-1:0]    sel,
  output logic               bad
);
  logic [AW-1:0] rf [NREG];
  logic [2:0]    mode_raw;
  pm_e           pm;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign rf[g] = regs[g*AW +: AW];
  end

  assign mode_raw = op[7:5];
  assign sel      = op[4:2];
  assign pm       = pm_e'(op[1:0]);

  always_comb begin
    base  = '0;
    wb_en = 1'b0;
    bad   = 1'b0;
    unique case (mode_raw)
      M_DIRECT:   base = offset;
      M_INDIRECT: begin
        base  = rf[sel];
        wb_en = (pm != PM_NONE);
      end
      M_INDEXED:  base = rf[sel] + rf[IDX_REG];
      M_LONG:     base = rf[sel] + offset;
      M_SHORT:    base = rf[PAGE_REG] + {{(AW-SHORT_W){1'b0}}, offset[SHORT_W-1:0]};
      default:    bad = 1'b1;
    endcase
    if (mode_raw != M_INDIRECT && pm != PM_NONE) bad = 1'b1;
  end

  always_comb begin
    if (is_str) begin
      step = AW'(1);
    end else begin
      unique case (pm)
        PM_INC:  step = AW'(1);
        PM_DEC:  step = {AW{1'b1}};
        PM_IDX:  step = rf[IDX_REG];
        default: step = '0;
      endcase
    end
  end
endmodule

// File: rtl/sag_seq.sv
module sag_seq
  import sag_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            bad,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   step,
  input  logic            wb_en,
  input  logic [SELW-1:0] sel,
  input  logic [LW-1:0]   len,
  input  logic            out_ready,
  output logic            addr_valid,
  output logic [AW-1:0]   addr,
  output logic            wb_valid,
  output logic [SELW-1:0] wb_idx,
  output logic [AW-1:0]   wb_data,
  output logic            busy,
  output logic            err
);
  logic            vld_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   step_q;
  logic            wb_q;
  logic [SELW-1:0] sel_q;
  logic [LW-1:0]   rem_q;
  logic            err_q;
  logic            beat;

  assign beat = vld_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      step_q <= '0;
      wb_q   <= 1'b0;
      sel_q  <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && bad;
      if (accept && !bad) begin
        vld_q  <= 1'b1;
        addr_q <= base;
        step_q <= step;
        wb_q   <= wb_en;
        sel_q  <= sel;
        rem_q  <= len;
      end else if (beat) begin
        if (rem_q == '0) begin
          vld_q <= 1'b0;
        end else begin
          addr_q <= addr_q + AW'(1);
          rem_q  <= rem_q - LW'(1);
        end
      end
    end
  end

  assign addr_valid = vld_q;
  assign addr       = addr_q;
  assign busy       = vld_q;
  assign err        = err_q;
  assign wb_valid   = beat && wb_q;
  assign wb_idx     = sel_q;
  assign wb_data    = addr_q + step_q;
endmodule

// File: rtl/str_addr_gen.sv
module str_addr_gen
  import sag_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         op,
  input  logic [AW-1:0]      offset,
  input  logic [LW-1:0]      str_len,
  input  logic [NREG*AW-1:0] regs,
  input  logic               out_ready,
  output logic               addr_valid,
  output logic [AW-1:0]      addr,
  output logic               wb_valid,
  output logic [SELW-1:0]    wb_idx,
  output logic [AW-1:0]      wb_data,
  output logic               busy,
  output logic               err
);
  logic            accept;
  logic [AW-1:0]   base;
  logic [AW-1:0]   step;
  logic            wb_en;
  logic [SELW-1:0] sel;
  logic            bad;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  sag_base_calc #(.AW(AW)) calc_i (
    .op     (op),
    .offset (offset),
    .regs   (regs),
    .is_str (|str_len),
    .base   (base),
    .step   (step),
    .wb_en  (wb_en),
    .sel    (sel),
    .bad    (bad)
  );

  sag_seq #(.AW(AW), .LW(LW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .bad        (bad),
    .base       (base),
    .step       (step),
    .wb_en      (wb_en),
    .sel        (sel),
    .len        (str_len),
    .out_ready  (out_ready),
    .addr_valid (addr_valid),
    .addr       (addr),
    .wb_valid   (wb_valid),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data),
    .busy       (busy),
    .err        (err)
  );
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_ready,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          wb_valid,
  input logic          err
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !out_ready |=> addr_valid && $stable(addr));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && out_ready |=> !addr_valid || addr == $past(addr) + AW'(1));

  assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !addr_valid && !wb_valid);

  assert_wb_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> addr_valid && out_ready);

  assert_accept_result_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> addr_valid || err);
endmodule

bind str_addr_gen sag_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_ready  (out_ready),
  .addr_valid (addr_valid),
  .addr       (addr),
  .wb_valid   (wb_valid),
  .err        (err)
);

// File: tb/str_addr_gen_tb_top.sv
module str_addr_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   op = '0;
  logic [15:0]  offset = '0;
  logic [7:0]   str_len = '0;
  logic [127:0] regs;
  logic         out_ready = 1'b1;
  logic         addr_valid;
  logic [15:0]  addr;
  logic         wb_valid;
  logic [2:0]   wb_idx;
  logic [15:0]  wb_data;
  logic         busy;
  logic         err;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  assign regs = {16'h7777, 16'h6000, 16'h0005, 16'h4444,
                 16'hFFFE, 16'h2222, 16'h1111, 16'h0100};

  str_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .offset(offset), .str_len(str_len), .regs(regs),
    .out_ready(out_ready), .addr_valid(addr_valid), .addr(addr),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .busy(busy), .err(err)
  );

  // op, offset, addr, wb_valid, wb_idx, wb_data, err
  localparam logic [60:0] VECS [16] = '{
    {8'h00, 16'hABCD, 16'hABCD, 1'b0, 3'd0, 16'h0000, 1'b0}, // R2
    {8'h28, 16'h0000, 16'h2222, 1'b0, 3'd0, 16'h0000, 1'b0}, // R3
    {8'h25, 16'h0000, 16'h1111, 1'b1, 3'd1, 16'h1112, 1'b0}, // R7
    {8'h32, 16'h0000, 16'h4444, 1'b1, 3'd4, 16'h4443, 1'b0}, // R7
    {8'h3F, 16'h0000, 16'h7777, 1'b1, 3'd7, 16'h777C, 1'b0}, // R7
    {8'h22, 16'h0000, 16'h0100, 1'b1, 3'd0, 16'h00FF, 1'b0}, // R7
    {8'h48, 16'h0000, 16'h2227, 1'b0, 3'd0, 16'h0000, 1'b0}, // R4
    {8'h4C, 16'h0000, 16'h0003, 1'b0, 3'd0, 16'h0000, 1'b0}, // R4 wrap
    {8'h70, 16'h1000, 16'h5444, 1'b0, 3'd0, 16'h0000, 1'b0}, // R6
    {8'h6C, 16'h0005, 16'h0003, 1'b0, 3'd0, 16'h0000, 1'b0}, // R6 wrap
    {8'h80, 16'h00FF, 16'h607F, 1'b0, 3'd0, 16'h0000, 1'b0}, // R5
    {8'h94, 16'hFF11, 16'h6011, 1'b0, 3'd0, 16'h0000, 1'b0}, // R5
    {8'hA0, 16'h0000, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1}, // R12
    {8'hE0, 16'h0000, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1}, // R12
    {8'h49, 16'h0000, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1}, // R12
    {8'h2D, 16'h0000, 16'hFFFE, 1'b1, 3'd3, 16'hFFFF, 1'b0}  // R7 wrap
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [7:0] o, input logic [15:0] off, input logic [7:0] n);
    @(negedge clk);
    op = o; offset = off; str_len = n; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; str_len = '0;
    #1;
  endtask

  task automatic run_seq(input logic [7:0] o, input logic [15:0] off, input int n,
                         input logic [15:0] base, input bit wbv, input logic [2:0] wbi,
                         input logic [15:0] wbd0, input bit stall, input bit poke,
                         input string req);
    issue(o, off, 8'(n));
    for (int k = 0; k <= n; k++) begin
      logic [15:0] e;
      e = base + 16'(k);
      if (stall && k == 1) begin
        out_ready = 1'b0;
        #1;
        check(addr_valid && addr == e && !wb_valid, "R11", {15'd0, addr_valid, addr}, {16'd1, e});
        @(negedge clk); #1;
        check(addr_valid && addr == e && !wb_valid, "R11", {15'd0, addr_valid, addr}, {16'd1, e});
        out_ready = 1'b1;
        #1;
      end
      if (poke && k == 1) begin
        op = 8'h00; offset = 16'hDEAD; in_valid = 1'b1;
      end
      if (poke && k == 2) in_valid = 1'b0;
      #1;
      check(addr_valid && addr == e, req, {15'd0, addr_valid, addr}, {16'd1, e});
      check(busy && !in_ready, "R13", {30'd0, busy, in_ready}, 32'h2);
      check(wb_valid == wbv, wbv ? "R10" : "R9", {31'd0, wb_valid}, {31'd0, wbv});
      if (wbv) begin
        logic [15:0] ew;
        ew = (n == 0) ? wbd0 : e + 16'd1;
        check(wb_idx == wbi && wb_data == ew, (n == 0) ? "R7" : "R10",
              {13'd0, wb_idx, wb_data}, {13'd0, wbi, ew});
      end
      @(negedge clk); #1;
    end
    check(!addr_valid && !busy && in_ready, "R8", {29'd0, addr_valid, busy, in_ready}, 32'h1);
    @(negedge clk); #1;
    check(!addr_valid && !err, poke ? "R13" : "R8", {30'd0, addr_valid, err}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(in_ready && !addr_valid && !busy && !wb_valid && !err, "R1",
          {27'd0, in_ready, addr_valid, busy, wb_valid, err}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready && !addr_valid && !busy && !err, "R1",
          {28'd0, in_ready, addr_valid, busy, err}, 32'h8);

    for (int i = 0; i < 16; i++) begin
      logic [60:0] v;
      v = VECS[i];
      if (v[0]) begin
        issue(v[60:53], v[52:37], 8'd0);
        check(err && !addr_valid && !wb_valid, "R12",
              {29'd0, err, addr_valid, wb_valid}, 32'h4);
        @(negedge clk); #1;
        check(!err && !addr_valid && in_ready, "R12",
              {29'd0, err, addr_valid, in_ready}, 32'h1);
      end else begin
        run_seq(v[60:53], v[52:37], 0, v[36:21], v[20], v[19:17], v[16:1],
                1'b0, 1'b0, "R2-vec");
      end
    end

    // R8/R9: indirect string without post-modify, R1 base
    run_seq(8'h24, 16'h0000, 3, 16'h1111, 1'b0, 3'd1, 16'h0, 1'b0, 1'b0, "R8");
    // R6/R8: long relative string wrapping past 16'hFFFF
    run_seq(8'h70, 16'hBBBA, 3, 16'hFFFE, 1'b0, 3'd4, 16'h0, 1'b0, 1'b0, "R6");
    // R10: post-modify string, action ignored, steps by one
    run_seq(8'h2B, 16'h0000, 2, 16'h2222, 1'b1, 3'd2, 16'h0, 1'b0, 1'b0, "R10");
    // R11: stall in a direct string
    run_seq(8'h00, 16'h0300, 2, 16'h0300, 1'b0, 3'd0, 16'h0, 1'b1, 1'b0, "R11");
    // R11 with post-modify string: no write-back while stalled
    run_seq(8'h25, 16'h0000, 2, 16'h1111, 1'b1, 3'd1, 16'h0, 1'b1, 1'b0, "R11");
    // R13: offer during busy is ignored
    run_seq(8'h48, 16'h0000, 3, 16'h2227, 1'b0, 3'd2, 16'h0, 1'b0, 1'b1, "R13");
    // R4: indexed string
    run_seq(8'h4C, 16'h0000, 1, 16'h0003, 1'b0, 3'd3, 16'h0, 1'b0, 1'b0, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule